// File: doc/BRIEF.md
# Unlock-Sequence Flash Command Decoder

This block sits on the write side of a flash bank controller. It watches the asynchronous bus write strobe. Each completed write cycle (address and data together, taken while the flash bank is selected) becomes one step of a multi-cycle unlock protocol. Only exact address/data pairs move the sequence forward. When a sequence completes, the block emits a single-cycle command pulse that carries the command kind, the latched target address and the data. The array and the engine that runs the internal program or erase act on that pulse.

Five sequences are decoded: byte program, sector erase, whole-bank erase, identification entry and identification exit. The block keeps an identification-mode flag and supplies the identification byte for the current read address. While the internal operation engine reports busy, every write cycle is discarded, so a running program or erase cannot be disturbed. Any write that breaks a sequence sends the decoder back to its idle read state.

Top module: `cmdseq_decoder`

## Requirements
- R1: During unlock and command steps only address bits 14..0 are compared. The first step must be 5555h with data AAh and the second 2AAAh with data 55h; higher address bits may hold any value.
- R2: After the two unlock steps, A0h written to 5555h arms a byte program. The next write produces a pulse with cmd_kind_o = 1 and the full write address and data on cmd_addr_o/cmd_data_o.
- R3: The sequence unlock, 80h to 5555h, AAh to 5555h, 55h to 2AAAh and then data 30h at any address produces cmd_kind_o = 2. cmd_addr_o carries address bits 18..12 of that last write with bits 11..0 zero (4 KB sectors), and cmd_data_o = 30h.
- R4: The same erase prefix followed by 10h written to 5555h produces cmd_kind_o = 3, cmd_addr_o = 0 and cmd_data_o = 10h. Data 10h at any other address produces no command.
- R5: Unlock followed by 90h to 5555h sets id_mode_o. Unlock followed by F0h to 5555h clears it. Neither produces a command pulse.
- R6: id_rdata_o is BFh when the read address is 0, DEV_ID (default 17h) when it is 1, and 00h for every other address.
- R7: A write that does not match the expected next step returns the decoder to idle and is not itself taken as a new first step. No command results, and a complete sequence afterwards is still accepted.
- R8: While op_busy_i is high, every write is ignored. No pulse is produced, id_mode_o does not change, and any partial sequence is dropped.
- R9: A strobe cycle with out_en_n_i low or flash_sel_n_i high is not a write. It neither advances nor aborts a sequence in progress.
- R10: cmd_valid_o is high for exactly one clock. It rises at the fourth rising clock edge counted from the first edge that samples wr_strobe_n_i high after a low period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | 19 | Bus address |
| bus_data_i | input | 8 | Bus write data |
| flash_sel_n_i | input | 1 | Flash bank select, active low |
| wr_strobe_n_i | input | 1 | Write strobe, active low, asynchronous |
| out_en_n_i | input | 1 | Output enable, active low |
| op_busy_i | input | 1 | Internal program/erase in progress |
| cmd_valid_o | output | 1 | One-cycle command pulse |
| cmd_kind_o | output | 2 | 1 program, 2 sector erase, 3 bank erase |
| cmd_addr_o | output | 19 | Target address (sector base for sector erase) |
| cmd_data_o | output | 8 | Program byte or erase code |
| id_mode_o | output | 1 | Identification mode active |
| id_rdata_o | output | 8 | Identification byte for bus_addr_i |

## Verification
The main sweep drives all 256 values into the third step after a valid unlock. It checks that only A0h, 90h and F0h have an effect, and that 80h opens an erase path without producing a command on its own. Directed sequences then separate sector erase from bank erase by varying the sixth-step data and address. They confirm that high address bits are ignored during unlock and that a broken second step aborts without restarting. Further cases set inhibited strobes (output enable low, bank deselected) against real aborts, and show that busy suppresses both commands and identification entry. A timed write pins down the pulse position and width.

// File: rtl/cmdseq_pkg.sv
package cmdseq_pkg;
    localparam int CMP_W = 15;
    localparam logic [CMP_W-1:0] KEY_ADDR_A = 15'h5555;
    localparam logic [CMP_W-1:0] KEY_ADDR_B = 15'h2AAA;
    localparam logic [7:0] KEY_DATA_A  = 8'hAA;
    localparam logic [7:0] KEY_DATA_B  = 8'h55;
    localparam logic [7:0] OP_PROGRAM  = 8'hA0;
    localparam logic [7:0] OP_ERASE    = 8'h80;
    localparam logic [7:0] OP_ID_ENTER = 8'h90;
    localparam logic [7:0] OP_ID_LEAVE = 8'hF0;
    localparam logic [7:0] OP_SECTOR   = 8'h30;
    localparam logic [7:0] OP_BANK     = 8'h10;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_KEY1,
        ST_KEY2,
        ST_PROG_ARM,
        ST_ERA_PFX,
        ST_ERA_KEY1,
        ST_ERA_KEY2
    } seq_state_e;

    typedef enum logic [1:0] {
        CK_NONE   = 2'd0,
        CK_PROG   = 2'd1,
        CK_SECTOR = 2'd2,
        CK_BANK   = 2'd3
    } cmd_kind_e;
endpackage

// File: rtl/cmdseq_capture.sv
module cmdseq_capture #(
    parameter int AW   = 19,
    parameter int DW   = 8,
    parameter int SYNC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] data_i,
    input  logic          sel_n_i,
    input  logic          wr_n_i,
    input  logic          oe_n_i,
    output logic          cyc_valid_o,
    output logic [AW-1:0] cyc_addr_o,
    output logic [DW-1:0] cyc_data_o
);
    localparam int TOP = SYNC - 1;

    typedef struct packed {
        logic [SYNC-1:0]         wr;
        logic [SYNC-1:0]         sel;
        logic [SYNC-1:0]         oe;
        logic [SYNC-1:0][AW-1:0] addr;
        logic [SYNC-1:0][DW-1:0] data;
        logic                    wr_prev;
        logic                    valid;
        logic [AW-1:0]           cap_addr;
        logic [DW-1:0]           cap_data;
    } cap_t;

    cap_t cap_d, cap_q;
    logic rise_ok;

    always_comb begin
        cap_d = cap_q;
        cap_d.wr[0]   = wr_n_i;
        cap_d.sel[0]  = sel_n_i;
        cap_d.oe[0]   = oe_n_i;
        cap_d.addr[0] = addr_i;
        cap_d.data[0] = data_i;
        for (int i = 1; i < SYNC; i++) begin
            cap_d.wr[i]   = cap_q.wr[i-1];
            cap_d.sel[i]  = cap_q.sel[i-1];
            cap_d.oe[i]   = cap_q.oe[i-1];
            cap_d.addr[i] = cap_q.addr[i-1];
            cap_d.data[i] = cap_q.data[i-1];
        end
        cap_d.wr_prev = cap_q.wr[TOP];
        // completed write: strobe just rose with bank selected and output disabled
        rise_ok = cap_q.wr[TOP] & ~cap_q.wr_prev & ~cap_q.sel[TOP] & cap_q.oe[TOP];
        cap_d.valid = rise_ok;
        if (rise_ok) begin
            cap_d.cap_addr = cap_q.addr[TOP];
            cap_d.cap_data = cap_q.data[TOP];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q          <= '0;
            cap_q.wr       <= '1;
            cap_q.sel      <= '1;
            cap_q.oe       <= '1;
            cap_q.wr_prev  <= 1'b1;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign cyc_valid_o = cap_q.valid;
    assign cyc_addr_o  = cap_q.cap_addr;
    assign cyc_data_o  = cap_q.cap_data;

    // R10: a captured write can never repeat in the following clock
    a_r10_cycle_single: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_valid_o |=> !cyc_valid_o);
endmodule

// File: rtl/cmdseq_fsm.sv
module cmdseq_fsm
    import cmdseq_pkg::*;
#(
    parameter int AW       = 19,
    parameter int DW       = 8,
    parameter int SECT_LSB = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          busy_i,
    input  logic          cyc_valid_i,
    input  logic [AW-1:0] cyc_addr_i,
    input  logic [DW-1:0] cyc_data_i,
    output logic          cmd_valid_o,
    output logic [1:0]    cmd_kind_o,
    output logic [AW-1:0] cmd_addr_o,
    output logic [DW-1:0] cmd_data_o,
    output logic          id_mode_o
);
    localparam int SECT_W = AW - SECT_LSB;

    typedef struct packed {
        seq_state_e    st;
        logic          valid;
        cmd_kind_e     kind;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic          id;
    } fsm_t;

    fsm_t f_d, f_q;
    logic at_a, at_b;
    logic [SECT_W-1:0] sect_idx;

    always_comb begin
        f_d       = f_q;
        f_d.valid = 1'b0;
        at_a      = cyc_addr_i[CMP_W-1:0] == KEY_ADDR_A;
        at_b      = cyc_addr_i[CMP_W-1:0] == KEY_ADDR_B;
        sect_idx  = cyc_addr_i[AW-1:SECT_LSB];
        if (busy_i) begin
            f_d.st = ST_IDLE;
        end else if (cyc_valid_i) begin
            f_d.st = ST_IDLE;
            unique case (f_q.st)
                ST_IDLE: begin
                    if (at_a && cyc_data_i == KEY_DATA_A) f_d.st = ST_KEY1;
                end
                ST_KEY1: begin
                    if (at_b && cyc_data_i == KEY_DATA_B) f_d.st = ST_KEY2;
                end
                ST_KEY2: begin
                    if (at_a) begin
                        unique case (cyc_data_i)
                            OP_PROGRAM:  f_d.st = ST_PROG_ARM;
                            OP_ERASE:    f_d.st = ST_ERA_PFX;
                            OP_ID_ENTER: f_d.id = 1'b1;
                            OP_ID_LEAVE: f_d.id = 1'b0;
                            default:     f_d.st = ST_IDLE;
                        endcase
                    end
                end
                ST_PROG_ARM: begin
                    f_d.valid = 1'b1;
                    f_d.kind  = CK_PROG;
                    f_d.addr  = cyc_addr_i;
                    f_d.data  = cyc_data_i;
                end
                ST_ERA_PFX: begin
                    if (at_a && cyc_data_i == KEY_DATA_A) f_d.st = ST_ERA_KEY1;
                end
                ST_ERA_KEY1: begin
                    if (at_b && cyc_data_i == KEY_DATA_B) f_d.st = ST_ERA_KEY2;
                end
                ST_ERA_KEY2: begin
                    if (cyc_data_i == OP_SECTOR) begin
                        f_d.valid = 1'b1;
                        f_d.kind  = CK_SECTOR;
                        f_d.addr  = {sect_idx, {SECT_LSB{1'b0}}};
                        f_d.data  = cyc_data_i;
                    end else if (cyc_data_i == OP_BANK && at_a) begin
                        f_d.valid = 1'b1;
                        f_d.kind  = CK_BANK;
                        f_d.addr  = '0;
                        f_d.data  = cyc_data_i;
                    end
                end
                default: f_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q      <= '0;
            f_q.st   <= ST_IDLE;
            f_q.kind <= CK_NONE;
        end else begin
            f_q <= f_d;
        end
    end

    assign cmd_valid_o = f_q.valid;
    assign cmd_kind_o  = f_q.kind;
    assign cmd_addr_o  = f_q.addr;
    assign cmd_data_o  = f_q.data;
    assign id_mode_o   = f_q.id;

    // R10: the command pulse lasts a single clock
    a_r10_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |=> !cmd_valid_o);
    // R8: a write arriving while busy never yields a command
    a_r8_busy_no_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && cyc_valid_i) |=> !cmd_valid_o);
    // R8: identification mode is frozen while busy
    a_r8_busy_id_stable: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> $stable(id_mode_o));
    // R7: every completed command leaves the sequencer idle
    a_r7_idle_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> f_q.st == ST_IDLE);
    // R5: identification mode only changes after a captured write
    a_r5_id_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_valid_i |=> $stable(id_mode_o));
endmodule

// File: rtl/cmdseq_idrom.sv
module cmdseq_idrom #(
    parameter int         AW     = 19,
    parameter logic [7:0] MFR_ID = 8'hBF,
    parameter logic [7:0] DEV_ID = 8'h17
) (
    input  logic [AW-1:0] addr_i,
    output logic [7:0]    rdata_o
);
    logic upper_zero;

    always_comb begin
        upper_zero = addr_i[AW-1:1] == '0;
        if (!upper_zero)     rdata_o = 8'h00;
        else if (addr_i[0])  rdata_o = DEV_ID;
        else                 rdata_o = MFR_ID;
        // R6: outside the two identification locations the byte is zero
        a_r6_id_outside: assert (upper_zero || rdata_o == 8'h00);
    end
endmodule

// File: rtl/cmdseq_decoder.sv
module cmdseq_decoder #(
    parameter int         AW       = 19,
    parameter int         SYNC     = 2,
    parameter int         SECT_LSB = 12,
    parameter logic [7:0] DEV_ID   = 8'h17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr_i,
    input  logic [7:0]    bus_data_i,
    input  logic          flash_sel_n_i,
    input  logic          wr_strobe_n_i,
    input  logic          out_en_n_i,
    input  logic          op_busy_i,
    output logic          cmd_valid_o,
    output logic [1:0]    cmd_kind_o,
    output logic [AW-1:0] cmd_addr_o,
    output logic [7:0]    cmd_data_o,
    output logic          id_mode_o,
    output logic [7:0]    id_rdata_o
);
    localparam int DW = 8;

    logic          cyc_valid;
    logic [AW-1:0] cyc_addr;
    logic [DW-1:0] cyc_data;

    cmdseq_capture #(.AW(AW), .DW(DW), .SYNC(SYNC)) u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_i     (bus_addr_i),
        .data_i     (bus_data_i),
        .sel_n_i    (flash_sel_n_i),
        .wr_n_i     (wr_strobe_n_i),
        .oe_n_i     (out_en_n_i),
        .cyc_valid_o(cyc_valid),
        .cyc_addr_o (cyc_addr),
        .cyc_data_o (cyc_data)
    );

    cmdseq_fsm #(.AW(AW), .DW(DW), .SECT_LSB(SECT_LSB)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .busy_i     (op_busy_i),
        .cyc_valid_i(cyc_valid),
        .cyc_addr_i (cyc_addr),
        .cyc_data_i (cyc_data),
        .cmd_valid_o(cmd_valid_o),
        .cmd_kind_o (cmd_kind_o),
        .cmd_addr_o (cmd_addr_o),
        .cmd_data_o (cmd_data_o),
        .id_mode_o  (id_mode_o)
    );

    cmdseq_idrom #(.AW(AW), .MFR_ID(8'hBF), .DEV_ID(DEV_ID)) u_idrom (
        .addr_i (bus_addr_i),
        .rdata_o(id_rdata_o)
    );

    // R2: a program command always carries kind 1..3, never the empty code
    a_r2_kind_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> cmd_kind_o != 2'd0);
endmodule

// File: tb/cmdseq_decoder_tb.sv
module cmdseq_decoder_tb;
    localparam int AW = 19;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [7:0]    bus_data = '0;
    logic          sel_n = 1'b1;
    logic          wr_n = 1'b1;
    logic          oe_n = 1'b1;
    logic          busy = 1'b0;
    logic          cmd_valid;
    logic [1:0]    cmd_kind;
    logic [AW-1:0] cmd_addr;
    logic [7:0]    cmd_data;
    logic          id_mode;
    logic [7:0]    id_rdata;

    int checks = 0;
    int failures = 0;
    int pulses = 0;
    logic [1:0]    last_kind = '0;
    logic [AW-1:0] last_addr = '0;
    logic [7:0]    last_data = '0;
    bit            done = 1'b0;

    always #4 clk = ~clk;

    cmdseq_decoder #(.AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr_i(bus_addr), .bus_data_i(bus_data),
        .flash_sel_n_i(sel_n), .wr_strobe_n_i(wr_n), .out_en_n_i(oe_n),
        .op_busy_i(busy), .cmd_valid_o(cmd_valid), .cmd_kind_o(cmd_kind),
        .cmd_addr_o(cmd_addr), .cmd_data_o(cmd_data), .id_mode_o(id_mode),
        .id_rdata_o(id_rdata)
    );

    always @(negedge clk) begin
        if (cmd_valid) begin
            pulses    <= pulses + 1;
            last_kind <= cmd_kind;
            last_addr <= cmd_addr;
            last_data <= cmd_data;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [7:0] d,
                             input logic sel = 1'b0, input logic oe = 1'b1);
        @(negedge clk);
        bus_addr = a; bus_data = d; sel_n = sel; oe_n = oe; wr_n = 1'b0;
        repeat (3) @(negedge clk);
        wr_n = 1'b1;
        repeat (3) @(negedge clk);
        sel_n = 1'b1; oe_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic unlock();
        bus_write(19'h05555, 8'hAA);
        bus_write(19'h02AAA, 8'h55);
    endtask

    task automatic erase_prefix();
        unlock();
        bus_write(19'h05555, 8'h80);
        unlock();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int p0;
        logic id_exp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // reset state
        check("R10 reset cmd_valid", cmd_valid, 0);
        check("R5 reset id_mode", id_mode, 0);

        // R10: exact pulse position on a timed program write
        unlock();
        bus_write(19'h05555, 8'hA0);
        @(negedge clk);
        bus_addr = 19'h12345; bus_data = 8'h5A; sel_n = 1'b0; wr_n = 1'b0;
        repeat (3) @(negedge clk);
        wr_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R10 no pulse before 4th edge", cmd_valid, 0);
        @(negedge clk);
        check("R10 pulse at 4th edge", cmd_valid, 1);
        check("R2 program kind", cmd_kind, 1);
        check("R2 program addr", cmd_addr, 19'h12345);
        check("R2 program data", cmd_data, 8'h5A);
        @(negedge clk);
        check("R10 pulse one cycle", cmd_valid, 0);
        sel_n = 1'b1;
        repeat (3) @(negedge clk);

        // R2/R5/R7: sweep every third-step byte
        id_exp = 1'b0;
        for (int d = 0; d < 256; d++) begin
            p0 = pulses;
            unlock();
            bus_write(19'h05555, d[7:0]);
            bus_write(19'h00000, 8'h00);
            if (d == 8'h90) id_exp = 1'b1;
            if (d == 8'hF0) id_exp = 1'b0;
            check($sformatf("R2 R5 sweep pulses d=%0h", d), pulses - p0, (d == 8'hA0) ? 1 : 0);
            check($sformatf("R5 sweep id_mode d=%0h", d), id_mode, id_exp);
            if (d == 8'hA0) begin
                check("R2 sweep kind", last_kind, 1);
                check("R2 sweep addr", last_addr, 0);
            end
        end

        // R1: upper address bits ignored during unlock
        p0 = pulses;
        bus_write(19'h45555, 8'hAA);
        bus_write(19'h72AAA, 8'h55);
        bus_write(19'h3D555, 8'hA0);
        bus_write(19'h7FFFF, 8'hC3);
        check("R1 high bits ignored pulses", pulses - p0, 1);
        check("R1 program data", last_data, 8'hC3);
        check("R1 program addr", last_addr, 19'h7FFFF);

        // R3: sector erase at several addresses
        for (int k = 0; k < 3; k++) begin
            logic [AW-1:0] sa;
            sa = (k == 0) ? 19'h7F123 : (k == 1) ? 19'h01FFF : 19'h00000;
            p0 = pulses;
            erase_prefix();
            bus_write(sa, 8'h30);
            check("R3 sector pulses", pulses - p0, 1);
            check("R3 sector kind", last_kind, 2);
            check("R3 sector base", last_addr, {sa[18:12], 12'h000});
            check("R3 sector data", last_data, 8'h30);
        end

        // R4: bank erase and a misplaced bank code
        p0 = pulses;
        erase_prefix();
        bus_write(19'h25555, 8'h10);
        check("R4 bank pulses", pulses - p0, 1);
        check("R4 bank kind", last_kind, 3);
        check("R4 bank addr", last_addr, 0);
        check("R4 bank data", last_data, 8'h10);
        p0 = pulses;
        erase_prefix();
        bus_write(19'h01234, 8'h10);
        check("R4 wrong addr no pulse", pulses - p0, 0);

        // R7: broken second step aborts; repeat of first step is not a restart
        p0 = pulses;
        bus_write(19'h05555, 8'hAA);
        bus_write(19'h02AAA, 8'h56);
        bus_write(19'h02AAA, 8'h55);
        bus_write(19'h05555, 8'hA0);
        bus_write(19'h00010, 8'h11);
        check("R7 abort no pulse", pulses - p0, 0);
        p0 = pulses;
        bus_write(19'h05555, 8'hAA);
        bus_write(19'h05555, 8'hAA);
        bus_write(19'h02AAA, 8'h55);
        bus_write(19'h05555, 8'hA0);
        bus_write(19'h00010, 8'h11);
        check("R7 mismatch first step not restart", pulses - p0, 0);
        p0 = pulses;
        unlock();
        bus_write(19'h05555, 8'hA0);
        bus_write(19'h00020, 8'h22);
        check("R7 recovery pulse", pulses - p0, 1);

        // R9: inhibited strobes neither advance nor abort
        p0 = pulses;
        bus_write(19'h05555, 8'hAA);
        bus_write(19'h00000, 8'h00, 1'b0, 1'b0);
        bus_write(19'h00000, 8'h00, 1'b1, 1'b1);
        bus_write(19'h02AAA, 8'h55);
        bus_write(19'h05555, 8'hA0);
        bus_write(19'h00040, 8'h44);
        check("R9 inhibited ignored pulses", pulses - p0, 1);
        check("R9 program data", last_data, 8'h44);

        // R8: busy ignores everything
        busy = 1'b1;
        p0 = pulses;
        unlock();
        bus_write(19'h05555, 8'hA0);
        bus_write(19'h00050, 8'h55);
        check("R8 busy program ignored", pulses - p0, 0);
        unlock();
        bus_write(19'h05555, 8'h90);
        check("R8 busy id entry ignored", id_mode, 0);
        unlock();
        busy = 1'b0;
        repeat (2) @(negedge clk);
        p0 = pulses;
        bus_write(19'h05555, 8'hA0);
        bus_write(19'h00060, 8'h66);
        check("R8 busy dropped partial sequence", pulses - p0, 0);

        // R5/R8: id mode held while busy
        unlock();
        bus_write(19'h05555, 8'h90);
        check("R5 id entry", id_mode, 1);
        busy = 1'b1;
        unlock();
        bus_write(19'h05555, 8'hF0);
        check("R8 busy id exit ignored", id_mode, 1);
        busy = 1'b0;
        repeat (2) @(negedge clk);
        unlock();
        bus_write(19'h05555, 8'hF0);
        check("R5 id exit", id_mode, 0);

        // R6: identification bytes
        @(negedge clk); bus_addr = 19'h00000; #1;
        check("R6 mfr id", id_rdata, 8'hBF);
        @(negedge clk); bus_addr = 19'h00001; #1;
        check("R6 dev id", id_rdata, 8'h17);
        @(negedge clk); bus_addr = 19'h00002; #1;
        check("R6 other addr", id_rdata, 8'h00);
        @(negedge clk); bus_addr = 19'h40001; #1;
        check("R6 high addr", id_rdata, 8'h00);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule